// File: doc/BRIEF.md
# Processor clock, reset and ready generator

This block derives the timing signals a processor and its peripherals need from one fast source. A select pin picks either the internal oscillator or an external frequency input. The chosen source is divided by three to give the processor clock, which is high for one source period and low for two. A second stage halves the processor clock to give a peripheral clock with an even duty cycle. A phase-sync input holds the divide-by-three counter in its start state, so that several such blocks can be aligned.

The whole block runs on one fast system clock `clk_i`. Each source edge arrives as a one-cycle tick on `osc_tick_i` or `ext_tick_i`, so every output is a register in the `clk_i` domain. A raw reset request, for example from an RC network, passes through two flip-flops that advance only on processor clock falling edges, so `cpu_rst_o` always changes in step with that edge. Two ready requests each come with an active-low enable. The qualified requests are ORed and passed through the same kind of two-stage pipeline to form `ready_o`.

Top module: `cgen_clkrst`

## Requirements
- R1: With a tick on every `clk_i` cycle, `cpu_clk_o` repeats with a period of 3 cycles and is high for 1 of them. In general it is high for one selected source period and low for two.
- R2: `per_clk_o` toggles only on a falling edge of `cpu_clk_o`. Its period is twice that of `cpu_clk_o`, at a 50% duty cycle (6 cycles, 3 high, with a tick every cycle).
- R3: `src_sel_i`=0 divides `osc_tick_i` and `src_sel_i`=1 divides `ext_tick_i`. Ticks on the unselected input have no effect on the outputs.
- R4: While `rst_ni` is low, the outputs are `cpu_clk_o`=0, `per_clk_o`=0, `cpu_rst_o`=1 and `ready_o`=0.
- R5: While `phase_sync_i` is 1, the divide counter is held at its start state and `cpu_clk_o` stays 0. After release, `cpu_clk_o` goes high on the second selected tick.
- R6: `cpu_rst_o` follows `rst_req_i` (active high) through two stages that sample only on falling edges of `cpu_clk_o`. It changes only on such an edge.
- R7: After `rst_req_i` falls, `cpu_rst_o` is still 1 after the first following falling edge of `cpu_clk_o` and is 0 after the second.
- R8: `ready_o` equals (`rdy_a_i` AND NOT `rdy_a_en_ni`) OR (`rdy_b_i` AND NOT `rdy_b_en_ni`), delayed by two falling edges of `cpu_clk_o`. It changes only on such an edge.
- R9: A ready input whose enable is 1 (not enabled) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| osc_tick_i | input | 1 | Internal oscillator edge tick |
| ext_tick_i | input | 1 | External frequency edge tick |
| src_sel_i | input | 1 | 0 = oscillator, 1 = external source |
| phase_sync_i | input | 1 | Holds the divide-by-three counter at its start state |
| rst_req_i | input | 1 | Asynchronous reset request, active high |
| rdy_a_i | input | 1 | Ready request A |
| rdy_a_en_ni | input | 1 | Active-low enable qualifying request A |
| rdy_b_i | input | 1 | Ready request B |
| rdy_b_en_ni | input | 1 | Active-low enable qualifying request B |
| cpu_clk_o | output | 1 | Processor clock, source divided by three |
| per_clk_o | output | 1 | Peripheral clock, processor clock divided by two |
| cpu_rst_o | output | 1 | Reset aligned to processor clock falling edges |
| ready_o | output | 1 | Synchronized merged ready |

## Verification
The assertions assume that tick inputs are single-cycle pulses in the `clk_i` domain. They also assume that `src_sel_i` does not change in the same cycle as a tick whose effect is being checked. The stimulus changes inputs only between samples taken just after a rising edge of `clk_i`. It holds `src_sel_i` steady across each measurement. It keeps every ready and reset request stable over at least two processor clock falling edges before it compares the outputs.

// File: rtl/cgen_pkg.sv
package cgen_pkg;
  localparam int unsigned DIV_RATIO_DEF  = 3;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef struct packed {
    logic req;
    logic en_n;
  } rdy_src_t;
endpackage

// File: rtl/cgen_div.sv
module cgen_div #(
  parameter int unsigned DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic div_o,
  output logic fall_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
    out_d = (cnt_d == LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign div_o  = out_q;
  assign fall_o = out_q & ~out_d;
endmodule

// File: rtl/cgen_toggle.sv
module cgen_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = ~q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cgen_sync.sv
module cgen_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q, st_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign st_d[i] = en_i ? d_i : st_q[i];
    end else begin : g_next
      assign st_d[i] = en_i ? st_q[i-1] : st_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cgen_clkrst.sv
module cgen_clkrst
  import cgen_pkg::*;
#(
  parameter int unsigned DIV_RATIO  = DIV_RATIO_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic ext_tick_i,
  input  logic src_sel_i,
  input  logic phase_sync_i,
  input  logic rst_req_i,
  input  logic rdy_a_i,
  input  logic rdy_a_en_ni,
  input  logic rdy_b_i,
  input  logic rdy_b_en_ni,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic cpu_rst_o,
  output logic ready_o
);
  logic     src_tick;
  logic     cpu_fall;
  logic     rdy_any;
  rdy_src_t rdy_a, rdy_b;

  // R3: source selection
  assign src_tick = src_sel_i ? ext_tick_i : osc_tick_i;

  // R1, R5: divide-by-three core
  cgen_div #(.DIV(DIV_RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (src_tick),
    .hold_i (phase_sync_i),
    .div_o  (cpu_clk_o),
    .fall_o (cpu_fall)
  );

  // R2: peripheral clock halves the processor clock
  cgen_toggle u_per (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cpu_fall),
    .q_o    (per_clk_o)
  );

  // R6, R7: reset request aligned to processor clock falling edges
  cgen_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cpu_fall),
    .d_i    (rst_req_i),
    .q_o    (cpu_rst_o)
  );

  // R8, R9: qualified ready merge
  assign rdy_a   = '{req: rdy_a_i, en_n: rdy_a_en_ni};
  assign rdy_b   = '{req: rdy_b_i, en_n: rdy_b_en_ni};
  assign rdy_any = (rdy_a.req & ~rdy_a.en_n) | (rdy_b.req & ~rdy_b.en_n);

  cgen_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_rdy_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cpu_fall),
    .d_i    (rdy_any),
    .q_o    (ready_o)
  );
endmodule

// File: rtl/cgen_clkrst_chk.sv
module cgen_clkrst_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_tick_i,
  input logic ext_tick_i,
  input logic src_sel_i,
  input logic phase_sync_i,
  input logic cpu_clk_o,
  input logic per_clk_o,
  input logic cpu_rst_o,
  input logic ready_o
);
  logic sel_tick;
  assign sel_tick = src_sel_i ? ext_tick_i : osc_tick_i;

  AST_CPU_HIGH_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_o && sel_tick && !phase_sync_i) |=> !cpu_clk_o); // R1
  AST_PER_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_clk_o) |-> $fell(cpu_clk_o)); // R2
  AST_NO_TICK_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_tick && !phase_sync_i) |=> $stable(cpu_clk_o)); // R3
  AST_SYNC_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_sync_i |=> !cpu_clk_o); // R5
  AST_RST_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpu_rst_o) |-> $fell(cpu_clk_o)); // R6
  AST_READY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ready_o) |-> $fell(cpu_clk_o)); // R8
endmodule

bind cgen_clkrst cgen_clkrst_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .osc_tick_i   (osc_tick_i),
  .ext_tick_i   (ext_tick_i),
  .src_sel_i    (src_sel_i),
  .phase_sync_i (phase_sync_i),
  .cpu_clk_o    (cpu_clk_o),
  .per_clk_o    (per_clk_o),
  .cpu_rst_o    (cpu_rst_o),
  .ready_o      (ready_o)
);

// File: tb/cgen_clkrst_tb.sv
`timescale 1ns/1ps
module cgen_clkrst_tb;
  logic clk = 1'b0;
  logic rst_ni, osc_tick_i, ext_tick_i, src_sel_i, phase_sync_i, rst_req_i;
  logic rdy_a_i, rdy_a_en_ni, rdy_b_i, rdy_b_en_ni;
  logic cpu_clk_o, per_clk_o, cpu_rst_o, ready_o;
  logic ext_run;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cgen_clkrst u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .ext_tick_i(ext_tick_i),
    .src_sel_i(src_sel_i), .phase_sync_i(phase_sync_i), .rst_req_i(rst_req_i),
    .rdy_a_i(rdy_a_i), .rdy_a_en_ni(rdy_a_en_ni), .rdy_b_i(rdy_b_i),
    .rdy_b_en_ni(rdy_b_en_ni), .cpu_clk_o(cpu_clk_o), .per_clk_o(per_clk_o),
    .cpu_rst_o(cpu_rst_o), .ready_o(ready_o)
  );

  // {rdy_a, en_a_n, rdy_b, en_b_n, expected ready}
  localparam logic [4:0] RDY_VEC [16] = '{
    5'b0000_0, 5'b0001_0, 5'b0010_1, 5'b0011_0,
    5'b0100_0, 5'b0101_0, 5'b0110_1, 5'b0111_0,
    5'b1000_1, 5'b1001_1, 5'b1010_1, 5'b1011_1,
    5'b1100_0, 5'b1101_0, 5'b1110_1, 5'b1111_0
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one clk cycle; sample and drive 1 ns after the rising edge
  task automatic step();
    @(posedge clk);
    #1;
    ext_tick_i = ext_run ? ~ext_tick_i : 1'b0;
  endtask

  task automatic wait_falls(input int n);
    int seen = 0;
    logic prev = cpu_clk_o;
    while (seen < n) begin
      step();
      if (prev && !cpu_clk_o) seen++;
      prev = cpu_clk_o;
    end
  endtask

  function automatic logic pick(input bit which);
    return which ? per_clk_o : cpu_clk_o;
  endfunction

  task automatic measure(input bit which, output int period, output int high);
    logic prev, s;
    s = pick(which);
    do begin prev = s; step(); s = pick(which); end while (!(!prev && s));
    period = 0; high = 0;
    do begin
      if (s) high++;
      period++;
      prev = s; step(); s = pick(which);
    end while (!(!prev && s));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int per, hi;
    rst_ni = 0; osc_tick_i = 1; ext_tick_i = 0; ext_run = 0; src_sel_i = 0;
    phase_sync_i = 0; rst_req_i = 1;
    rdy_a_i = 0; rdy_a_en_ni = 1; rdy_b_i = 0; rdy_b_en_ni = 1;
    repeat (4) step();
    check("R4 cpu_clk in reset", cpu_clk_o, 0);
    check("R4 per_clk in reset", per_clk_o, 0);
    check("R4 cpu_rst in reset", cpu_rst_o, 1);
    check("R4 ready in reset", ready_o, 0);
    rst_ni = 1;

    // ready vector table
    for (int i = 0; i < 16; i++) begin
      {rdy_a_i, rdy_a_en_ni, rdy_b_i, rdy_b_en_ni} = RDY_VEC[i][4:1];
      wait_falls(2);
      check($sformatf("R8/R9 ready vector %0d", i), ready_o, RDY_VEC[i][0]);
    end

    // R8 two-edge latency
    rdy_a_i = 1; rdy_a_en_ni = 0; rdy_b_i = 0; rdy_b_en_ni = 1;
    wait_falls(2);
    rdy_a_i = 0;
    wait_falls(1);
    check("R8 ready after one fall", ready_o, 1);
    wait_falls(1);
    check("R8 ready after two falls", ready_o, 0);

    // R1 / R2 with oscillator every cycle
    measure(0, per, hi);
    check("R1 cpu period", per, 3);
    check("R1 cpu high", hi, 1);
    measure(1, per, hi);
    check("R2 per period", per, 6);
    check("R2 per high", hi, 3);

    // R3 external source, ticking every other cycle; oscillator still ticking
    ext_run = 1; src_sel_i = 1;
    repeat (8) step();
    measure(0, per, hi);
    check("R3 ext cpu period", per, 6);
    check("R3 ext cpu high", hi, 2);
    // oscillator selected but stopped: external ticks ignored
    wait_falls(1);
    osc_tick_i = 0; src_sel_i = 0;
    begin
      int changes = 0;
      logic p = cpu_clk_o;
      logic pp = per_clk_o;
      for (int k = 0; k < 12; k++) begin
        step();
        if (cpu_clk_o != p || per_clk_o != pp) changes++;
      end
      check("R3 unselected ticks ignored", changes, 0);
    end
    ext_run = 0; osc_tick_i = 1;

    // R5 phase sync
    phase_sync_i = 1;
    begin
      int highs = 0;
      step();
      for (int k = 0; k < 6; k++) begin step(); if (cpu_clk_o) highs++; end
      check("R5 cpu low while held", highs, 0);
    end
    phase_sync_i = 0;
    step();
    check("R5 after first tick", cpu_clk_o, 0);
    step();
    check("R5 rises on second tick", cpu_clk_o, 1);
    step();
    check("R5 low on third tick", cpu_clk_o, 0);

    // R6 / R7 reset request
    check("R6 reset held while requested", cpu_rst_o, 1);
    rst_req_i = 0;
    wait_falls(1);
    check("R7 reset after one fall", cpu_rst_o, 1);
    wait_falls(1);
    check("R7 reset after two falls", cpu_rst_o, 0);
    rst_req_i = 1;
    step();
    check("R6 no change before fall", cpu_rst_o, 0);
    wait_falls(2);
    check("R6 reset reasserted", cpu_rst_o, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule